// File: doc/BRIEF.md
# I2C Slave Command Buffer Front-End

This block sits on an I2C bus as a write-only slave. It watches oversampled SCL and SDA lines and finds START and STOP conditions in them. It answers to a seven-bit address whose upper four bits are fixed and whose lower three come from select pins captured at reset. Once addressed for a write, it takes the first byte as a function code and stores every later byte, in arrival order, through a simple buffer write port. It acknowledges each byte by pulling SDA low for the ninth clock.

When the STOP arrives, the block checks the function code. A code in the range 01h to 0Fh is a request for a serial-peripheral transfer. For such a code the block presents the function code, the number of stored bytes and a four-line slave-select mask taken from the low nibble, and issues a one-cycle go strobe. From then on it stays silent on the bus, its own address included, until the executor reports completion on its done input. Any other code leaves the block idle after STOP.

Top module: `i2c_cmd_frontend`

## Requirements
- R1: The block acknowledges an address byte only when its upper seven bits equal 0101 followed by the three captured select bits and its last bit is 0 (write). Any other address byte, a read request included, is not acknowledged, and the rest of that frame up to the next START is not acknowledged either.
- R2: The select pins are captured while reset is high and never again, so a change on them after reset does not change the address that is answered.
- R3: An acknowledge holds SDA low from the SCL falling edge that ends the eighth bit of a byte until the SCL falling edge that ends the ninth clock, and then releases SDA.
- R4: The byte after the address appears on func_id_o. Each following byte is written to buffer addresses 0, 1, 2, ... in order, with a one-cycle buf_we_o per byte.
- R5: On STOP with a function code from 01h to 0Fh, go_o pulses for exactly one cycle, byte_cnt_o holds the number of stored data bytes, and bit i of ss_mask_o equals bit i of the function code for i = 0..3.
- R6: After a go pulse the block acknowledges nothing, its own address included, and issues neither writes nor a second go until done_i is seen high for one cycle.
- R7: Data bytes beyond the 200th in one frame are not acknowledged and not written, and byte_cnt_o stays at 200.
- R8: A function code of 00h or of 10h and above raises no go pulse, and the next message after STOP is acknowledged normally.
- R9: A repeated START in the middle of a frame discards that frame: the byte count restarts at zero, address matching begins again, and only the final frame can raise go.
- R10: After reset, sda_pull_o, go_o and buf_we_o are 0, byte_cnt_o is 0 and ss_mask_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock; it oversamples the bus lines |
| rst_i | input | 1 | Synchronous active-high reset; the select pins are captured while it is high |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| addr_pins_i | input | 3 | Low three bits of the slave address |
| done_i | input | 1 | Executor reports that the commanded function is complete |
| sda_pull_o | output | 1 | Drives the SDA pad low when 1 |
| buf_we_o | output | 1 | Buffer write strobe, one cycle per stored byte |
| buf_addr_o | output | 8 | Buffer write address |
| buf_data_o | output | 8 | Buffer write data |
| func_id_o | output | 8 | Function code of the current or last frame |
| byte_cnt_o | output | 8 | Number of data bytes stored in the frame |
| go_o | output | 1 | One-cycle request to start the function |
| ss_mask_o | output | 4 | Slave-select lines enabled for the transfer |

## Verification
The hardest case to reach from the ports is the buffer filling up: it needs more than two hundred full byte transactions in one frame before the refusal of byte 201 shows. The bench sends one directed 202-byte frame and checks that the acknowledge stops at exactly byte 200, that the write count stops there too, and that the count saturates. The busy lockout is the next hardest, because it shows only through missing acknowledges. After every accepted command, the bench addresses the block again before it pulses done and expects a NACK and no second go. Frames with random function codes and lengths, a repeated START mid-frame and address pins that change after reset fill in the rest.

// File: rtl/i2c_cmd_pkg.sv
package i2c_cmd_pkg;

    localparam int         BUF_DEPTH  = 200;
    localparam int         SS_LINES   = 4;
    localparam int         BYTE_W     = 8;
    localparam int         SEL_W      = 3;
    localparam logic [3:0] ADDR_FIXED = 4'b0101;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RECV,
        ST_ACK,
        ST_SKIP,
        ST_BUSY
    } fe_state_e;

    typedef enum logic [1:0] {
        BK_ADDR,
        BK_FUNC,
        BK_DATA
    } byte_kind_e;

    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_evt_t;

    function automatic logic addr_match(input logic [BYTE_W-1:0] b,
                                        input logic [3:0]        fixed,
                                        input logic [SEL_W-1:0]  sel);
        return (b[BYTE_W-1:1] == {fixed, sel}) && !b[0];
    endfunction

endpackage

// File: rtl/i2c_line_sampler.sv
module i2c_line_sampler
    import i2c_cmd_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk_i,
    input  logic     rst_i,
    input  logic     scl_i,
    input  logic     sda_i,
    output bus_evt_t evt_o,
    output logic     sda_o
);
    logic [SYNC_STAGES:0] scl_pipe;
    logic [SYNC_STAGES:0] sda_pipe;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
        end else begin
            scl_pipe <= {scl_pipe[SYNC_STAGES-1:0], scl_i};
            sda_pipe <= {sda_pipe[SYNC_STAGES-1:0], sda_i};
        end
    end

    logic scl_now, scl_old, sda_now, sda_old;
    assign scl_now = scl_pipe[SYNC_STAGES-1];
    assign scl_old = scl_pipe[SYNC_STAGES];
    assign sda_now = sda_pipe[SYNC_STAGES-1];
    assign sda_old = sda_pipe[SYNC_STAGES];

    always_comb begin
        evt_o.scl_rise = scl_now & ~scl_old;
        evt_o.scl_fall = ~scl_now & scl_old;
        evt_o.start    = scl_now & scl_old & sda_old & ~sda_now;
        evt_o.stop     = scl_now & scl_old & ~sda_old & sda_now;
    end

    assign sda_o = sda_now;
endmodule

// File: rtl/i2c_bit_shifter.sv
module i2c_bit_shifter #(
    parameter int W = 8,
    localparam int CNT_W = $clog2(W + 1)
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic         clear_i,
    input  logic         shift_i,
    input  logic         bit_i,
    output logic [W-1:0] data_o,
    output logic         full_o
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk_i) begin
        if (rst_i || clear_i) begin
            cnt_q  <= '0;
            data_o <= '0;
        end else if (shift_i) begin
            data_o <= {data_o[W-2:0], bit_i};
            cnt_q  <= cnt_q + CNT_W'(1);
        end
    end

    assign full_o = (cnt_q == CNT_W'(W));
endmodule

// File: rtl/cmd_func_decode.sv
module cmd_func_decode #(
    parameter int FUNC_W   = 8,
    parameter int SS_LINES = 4
) (
    input  logic [FUNC_W-1:0]   func_i,
    output logic                valid_o,
    output logic [SS_LINES-1:0] mask_o
);
    assign valid_o = (func_i[FUNC_W-1:SS_LINES] == '0) &&
                     (func_i[SS_LINES-1:0] != '0);

    for (genvar g = 0; g < SS_LINES; g++) begin : g_line
        assign mask_o[g] = func_i[g];
    end
endmodule

// File: rtl/i2c_cmd_frontend.sv
module i2c_cmd_frontend
    import i2c_cmd_pkg::*;
#(
    parameter int          BUF_DEPTH  = i2c_cmd_pkg::BUF_DEPTH,
    parameter int          SS_LINES   = i2c_cmd_pkg::SS_LINES,
    parameter logic [3:0]  ADDR_FIXED = i2c_cmd_pkg::ADDR_FIXED,
    localparam int         CNT_W      = $clog2(BUF_DEPTH + 1),
    localparam int         PTR_W      = $clog2(BUF_DEPTH)
) (
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic                scl_i,
    input  logic                sda_i,
    input  logic [SEL_W-1:0]    addr_pins_i,
    input  logic                done_i,
    output logic                sda_pull_o,
    output logic                buf_we_o,
    output logic [PTR_W-1:0]    buf_addr_o,
    output logic [BYTE_W-1:0]   buf_data_o,
    output logic [BYTE_W-1:0]   func_id_o,
    output logic [CNT_W-1:0]    byte_cnt_o,
    output logic                go_o,
    output logic [SS_LINES-1:0] ss_mask_o
);
    bus_evt_t           evt;
    logic               sda_s;
    logic [BYTE_W-1:0]  sh_data;
    logic               sh_full;
    logic               sh_clear;
    logic               sh_shift;
    logic               func_ok;
    logic [SS_LINES-1:0] dec_mask;

    fe_state_e          st_q;
    byte_kind_e         kind_q;
    logic               ack_flag_q;
    logic               ack_phase_q;
    logic               func_seen_q;
    logic [SEL_W-1:0]   addr_sel_q;
    logic               busy_w;
    logic [SEL_W-1:0]   addr_sel_w;

    i2c_line_sampler #(.SYNC_STAGES(2)) u_sampler (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .evt_o (evt),
        .sda_o (sda_s)
    );

    assign sh_shift = (st_q == ST_RECV) && evt.scl_rise;
    assign sh_clear = evt.start || ((st_q == ST_RECV) && sh_full);

    i2c_bit_shifter #(.W(BYTE_W)) u_shifter (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .clear_i (sh_clear),
        .shift_i (sh_shift),
        .bit_i   (sda_s),
        .data_o  (sh_data),
        .full_o  (sh_full)
    );

    cmd_func_decode #(.FUNC_W(BYTE_W), .SS_LINES(SS_LINES)) u_decode (
        .func_i  (func_id_o),
        .valid_o (func_ok),
        .mask_o  (dec_mask)
    );

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q        <= ST_IDLE;
            kind_q      <= BK_ADDR;
            ack_flag_q  <= 1'b0;
            ack_phase_q <= 1'b0;
            func_seen_q <= 1'b0;
            addr_sel_q  <= addr_pins_i;
            sda_pull_o  <= 1'b0;
            buf_we_o    <= 1'b0;
            buf_addr_o  <= '0;
            buf_data_o  <= '0;
            func_id_o   <= '0;
            byte_cnt_o  <= '0;
            go_o        <= 1'b0;
            ss_mask_o   <= '0;
        end else begin
            go_o     <= 1'b0;
            buf_we_o <= 1'b0;
            if (st_q == ST_BUSY) begin
                if (done_i) st_q <= ST_IDLE;
            end else if (evt.start) begin
                st_q        <= ST_RECV;
                kind_q      <= BK_ADDR;
                byte_cnt_o  <= '0;
                func_seen_q <= 1'b0;
                ack_phase_q <= 1'b0;
                sda_pull_o  <= 1'b0;
            end else if (evt.stop) begin
                sda_pull_o <= 1'b0;
                if (func_seen_q && func_ok) begin
                    go_o      <= 1'b1;
                    ss_mask_o <= dec_mask;
                    st_q      <= ST_BUSY;
                end else begin
                    st_q <= ST_IDLE;
                end
            end else begin
                unique case (st_q)
                    ST_RECV: begin
                        if (sh_full) begin
                            ack_phase_q <= 1'b0;
                            unique case (kind_q)
                                BK_ADDR: begin
                                    if (addr_match(sh_data, ADDR_FIXED, addr_sel_q)) begin
                                        ack_flag_q <= 1'b1;
                                        kind_q     <= BK_FUNC;
                                        st_q       <= ST_ACK;
                                    end else begin
                                        st_q <= ST_SKIP;
                                    end
                                end
                                BK_FUNC: begin
                                    func_id_o   <= sh_data;
                                    func_seen_q <= 1'b1;
                                    ack_flag_q  <= 1'b1;
                                    kind_q      <= BK_DATA;
                                    st_q        <= ST_ACK;
                                end
                                default: begin
                                    if (byte_cnt_o < CNT_W'(BUF_DEPTH)) begin
                                        buf_we_o   <= 1'b1;
                                        buf_addr_o <= byte_cnt_o[PTR_W-1:0];
                                        buf_data_o <= sh_data;
                                        byte_cnt_o <= byte_cnt_o + CNT_W'(1);
                                        ack_flag_q <= 1'b1;
                                    end else begin
                                        ack_flag_q <= 1'b0;
                                    end
                                    st_q <= ST_ACK;
                                end
                            endcase
                        end
                    end
                    ST_ACK: begin
                        if (evt.scl_fall) begin
                            if (!ack_phase_q) begin
                                sda_pull_o  <= ack_flag_q;
                                ack_phase_q <= 1'b1;
                            end else begin
                                sda_pull_o <= 1'b0;
                                st_q       <= ST_RECV;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign busy_w     = (st_q == ST_BUSY);
    assign addr_sel_w = addr_sel_q;
endmodule

// File: rtl/i2c_cmd_frontend_chk.sv
module i2c_cmd_frontend_chk #(
    parameter int BUF_DEPTH = 200,
    parameter int SS_LINES  = 4,
    parameter int CNT_W     = 8,
    parameter int PTR_W     = 8
) (
    input logic                clk_i,
    input logic                rst_i,
    input logic                busy_i,
    input logic                sda_pull_i,
    input logic                go_i,
    input logic [SS_LINES-1:0] mask_i,
    input logic [7:0]          func_i,
    input logic [CNT_W-1:0]    cnt_i,
    input logic                we_i,
    input logic [PTR_W-1:0]    waddr_i,
    input logic [2:0]          addr_sel_i
);
    // R6: no pull on SDA while waiting for the executor
    a_r6_quiet_while_busy: assert property (@(posedge clk_i) disable iff (rst_i)
        busy_i |-> !sda_pull_i);

    // R6: no buffer writes while waiting for the executor
    a_r6_no_write_busy: assert property (@(posedge clk_i) disable iff (rst_i)
        busy_i |-> !we_i);

    // R5: go lasts one cycle
    a_r5_go_single: assert property (@(posedge clk_i) disable iff (rst_i)
        go_i |=> !go_i);

    // R5: mask matches the low nibble of a supported function code
    a_r5_go_mask: assert property (@(posedge clk_i) disable iff (rst_i)
        go_i |-> (mask_i == func_i[SS_LINES-1:0]) && (mask_i != '0) &&
                 (func_i[7:SS_LINES] == '0));

    // R7: count never exceeds the buffer depth
    a_r7_count_cap: assert property (@(posedge clk_i) disable iff (rst_i)
        cnt_i <= CNT_W'(BUF_DEPTH));

    // R4: writes stay inside the buffer and are single pulses
    a_r4_wr_in_range: assert property (@(posedge clk_i) disable iff (rst_i)
        we_i |-> (waddr_i < PTR_W'(BUF_DEPTH)));

    a_r4_wr_pulse: assert property (@(posedge clk_i) disable iff (rst_i)
        we_i |=> !we_i);

    // R2: captured address bits do not move after reset
    a_r2_addr_frozen: assert property (@(posedge clk_i) disable iff (rst_i)
        !$past(rst_i) |-> $stable(addr_sel_i));
endmodule

bind i2c_cmd_frontend i2c_cmd_frontend_chk #(
    .BUF_DEPTH (BUF_DEPTH),
    .SS_LINES  (SS_LINES),
    .CNT_W     (CNT_W),
    .PTR_W     (PTR_W)
) chk_i (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .busy_i     (busy_w),
    .sda_pull_i (sda_pull_o),
    .go_i       (go_o),
    .mask_i     (ss_mask_o),
    .func_i     (func_id_o),
    .cnt_i      (byte_cnt_o),
    .we_i       (buf_we_o),
    .waddr_i    (buf_addr_o),
    .addr_sel_i (addr_sel_w)
);

// File: tb/i2c_cmd_frontend_tb_top.sv
`timescale 1ns/1ps
module i2c_cmd_frontend_tb_top;
    localparam int DEPTH = 200;
    localparam int HALF  = 8;
    localparam logic [2:0] ASEL = 3'b101;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic [2:0] addr_pins = ASEL;
    logic       done = 1'b0;

    logic       sda_pull, buf_we, go;
    logic [7:0] buf_addr, buf_data, func_id, byte_cnt;
    logic [3:0] ss_mask;
    logic       sda_line;

    assign sda_line = sda_m & ~sda_pull;

    always #2 clk = ~clk;

    i2c_cmd_frontend dut_i (
        .clk_i       (clk),
        .rst_i       (rst),
        .scl_i       (scl_m),
        .sda_i       (sda_line),
        .addr_pins_i (addr_pins),
        .done_i      (done),
        .sda_pull_o  (sda_pull),
        .buf_we_o    (buf_we),
        .buf_addr_o  (buf_addr),
        .buf_data_o  (buf_data),
        .func_id_o   (func_id),
        .byte_cnt_o  (byte_cnt),
        .go_o        (go),
        .ss_mask_o   (ss_mask)
    );

    int checks = 0;
    int errors = 0;
    int wr_cnt = 0;
    int go_cnt = 0;
    logic [7:0] bmem [0:255];
    logic [7:0] msg  [0:255];

    always @(posedge clk) begin
        if (buf_we) begin
            bmem[buf_addr] <= buf_data;
            wr_cnt <= wr_cnt + 1;
        end
        if (go) go_cnt <= go_cnt + 1;
    end

    function automatic bit exp_valid(input logic [7:0] f);
        return (f >= 8'h01) && (f <= 8'h0F);
    endfunction

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic m_start();
        sda_m = 1'b1; tick(HALF);
        scl_m = 1'b1; tick(HALF);
        sda_m = 1'b0; tick(HALF);
        scl_m = 1'b0; tick(HALF);
    endtask

    task automatic m_stop();
        sda_m = 1'b0; tick(HALF);
        scl_m = 1'b1; tick(HALF);
        sda_m = 1'b1; tick(2 * HALF);
    endtask

    task automatic m_byte(input logic [7:0] b, output bit acked);
        bit held;
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; tick(HALF);
            scl_m = 1'b1; tick(HALF);
            scl_m = 1'b0;
        end
        sda_m = 1'b1; tick(HALF);
        acked = !sda_line;
        scl_m = 1'b1; tick(HALF);
        held = !sda_line;
        scl_m = 1'b0; tick(6);
        chk(held == acked, "R3", "ack held through ninth clock", held, acked);
        chk(sda_pull == 1'b0, "R3", "SDA released after ninth clock", sda_pull, 0);
    endtask

    task automatic pulse_done();
        done = 1'b1; tick(1);
        done = 1'b0; tick(4);
    endtask

    task automatic do_msg(input logic [7:0] f, input int n);
        int  bw, bg, expn, bad;
        bit  a;
        bw = wr_cnt; bg = go_cnt;
        m_start();
        m_byte({4'b0101, ASEL, 1'b0}, a);
        chk(a, "R1", "own write address acked", a, 1);
        m_byte(f, a);
        chk(a, "R4", "function byte acked", a, 1);
        for (int k = 0; k < n; k++) begin
            m_byte(msg[k], a);
            if (k < DEPTH) chk(a == 1'b1, "R4", "data byte acked", a, 1);
            else           chk(a == 1'b0, "R7", "overflow byte nacked", a, 0);
        end
        m_stop();
        tick(10);
        expn = (n < DEPTH) ? n : DEPTH;
        if (exp_valid(f))
            chk(go_cnt - bg == 1, "R5", "go pulses for supported code", go_cnt - bg, 1);
        else
            chk(go_cnt - bg == 0, "R8", "no go for unsupported code", go_cnt - bg, 0);
        chk(wr_cnt - bw == expn, "R7", "bytes written", wr_cnt - bw, expn);
        chk(int'(byte_cnt) == expn, "R5", "byte count", byte_cnt, expn);
        chk(func_id == f, "R4", "function id", func_id, f);
        bad = 0;
        for (int k = 0; k < expn; k++) if (bmem[k] !== msg[k]) bad++;
        chk(bad == 0, "R4", "buffer mismatches", bad, 0);
        if (exp_valid(f)) begin
            chk(ss_mask == f[3:0], "R5", "slave-select mask", ss_mask, f[3:0]);
            bg = go_cnt; bw = wr_cnt;
            m_start();
            m_byte({4'b0101, ASEL, 1'b0}, a);
            chk(!a, "R6", "own address nacked while busy", a, 0);
            m_byte(8'h01, a);
            chk(!a, "R6", "byte nacked while busy", a, 0);
            m_stop();
            tick(10);
            chk(go_cnt == bg, "R6", "no go while busy", go_cnt - bg, 0);
            chk(wr_cnt == bw, "R6", "no write while busy", wr_cnt - bw, 0);
            pulse_done();
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish, actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        bit a;
        int bg;
        logic [7:0] f;
        void'($urandom(32'd20240611));
        tick(5);
        rst = 1'b0;
        addr_pins = 3'b010;
        tick(3);
        // R10 reset state
        chk(sda_pull == 1'b0, "R10", "sda_pull after reset", sda_pull, 0);
        chk(go == 1'b0, "R10", "go after reset", go, 0);
        chk(buf_we == 1'b0, "R10", "buf_we after reset", buf_we, 0);
        chk(byte_cnt == 8'd0, "R10", "byte_cnt after reset", byte_cnt, 0);
        chk(ss_mask == 4'd0, "R10", "ss_mask after reset", ss_mask, 0);

        // R2: the pins now show 010, which must not be answered
        bg = go_cnt;
        m_start();
        m_byte({4'b0101, 3'b010, 1'b0}, a);
        chk(!a, "R2", "post-reset pin value not answered", a, 0);
        m_stop();

        // R1: wrong select bits, then the frame is ignored
        m_start();
        m_byte({4'b0101, ASEL ^ 3'b001, 1'b0}, a);
        chk(!a, "R1", "foreign address nacked", a, 0);
        m_byte(8'h03, a);
        chk(!a, "R1", "bytes after foreign address ignored", a, 0);
        m_stop();
        // R1: read request
        m_start();
        m_byte({4'b0101, ASEL, 1'b1}, a);
        chk(!a, "R1", "read request nacked", a, 0);
        m_stop();
        tick(10);
        chk(go_cnt == bg, "R1", "no go from ignored frames", go_cnt - bg, 0);

        // R5: supported code with no data bytes
        do_msg(8'h09, 0);
        // R8: code 00h with data, then a normal message
        for (int k = 0; k < 4; k++) msg[k] = 8'(k * 37 + 5);
        do_msg(8'h00, 4);
        do_msg(8'h05, 4);

        // R9: repeated start aborts the first frame
        bg = go_cnt;
        m_start();
        m_byte({4'b0101, ASEL, 1'b0}, a);
        m_byte(8'h03, a);
        m_byte(8'hAA, a);
        m_byte(8'hBB, a);
        m_start();
        m_byte({4'b0101, ASEL, 1'b0}, a);
        chk(a, "R9", "address acked after repeated start", a, 1);
        m_byte(8'h06, a);
        m_byte(8'h5C, a);
        m_stop();
        tick(10);
        chk(go_cnt - bg == 1, "R9", "single go after repeated start", go_cnt - bg, 1);
        chk(func_id == 8'h06, "R9", "function of last frame", func_id, 8'h06);
        chk(byte_cnt == 8'd1, "R9", "count restarted", byte_cnt, 1);
        chk(bmem[0] == 8'h5C, "R9", "buffer slot 0 from last frame", bmem[0], 8'h5C);
        chk(ss_mask == 4'h6, "R9", "mask of last frame", ss_mask, 6);
        pulse_done();

        // randomized messages
        for (int m = 0; m < 8; m++) begin
            int n, sel;
            sel = int'($urandom % 4);
            if (sel == 0)      f = 8'h00;
            else if (sel == 1) f = 8'(8'h10 + ($urandom % 240));
            else               f = 8'(1 + ($urandom % 15));
            n = int'($urandom % 10);
            for (int k = 0; k < n; k++) msg[k] = 8'($urandom);
            do_msg(f, n);
        end

        // R7: overflow past the buffer depth
        for (int k = 0; k < DEPTH + 2; k++) msg[k] = 8'(k ^ 8'h3C);
        do_msg(8'h0F, DEPTH + 2);

        summary();
        $finish;
    end
endmodule